// File: doc/BRIEF.md
# Programmable Integration Period Sequencer

This block times one integration window of an integrating A/D converter. A host loads a 16-bit period setting as two configuration bytes, one strobe per byte. A start pulse launches a conversion. An internal counter driven by the system clock then runs. The setting is compared against the counter's upper bits only, and its lowest five bits act as a fixed divide-by-32 prescale. A conversion therefore lasts exactly 32 clocks for each unit of the setting. A setting of zero selects the longest period the counter can measure, so no window ever has zero length.

The modulator and filter that produce the conversion result are outside this block. They appear as a result word with a valid strobe. The block keeps the latest strobed word in a shadow register. When the window closes, it copies that word to the published data output and raises data-ready. The published output changes at no other time, so a read during a conversion returns the last completed result. Data-ready stays high until the next start.

Top module: `integ_seq`

## Requirements
- R1: While reset is asserted and right after it, `ready_o` and `busy_o` are 0 and `data_o` is 0.
- R2: The period setting N is `{cfg_hi, cfg_lo}` truncated to SET_W bits. A pulse on `cfg_lo_we` loads `cfg_wdata` into bits 7:0, and a pulse on `cfg_hi_we` loads it into bits 15:8.
- R3: For N between 1 and 2^SET_W-1, `ready_o` rises exactly 32·N clock edges after the edge that samples `start_i` high.
- R4: A setting of N = 0 gives a window of 2^SET_W·32 clock edges.
- R5: A sampled start clears `ready_o` and sets `busy_o` on the same edge. A start that arrives while busy restarts the window from zero.
- R6: The setting is captured when the start is sampled. Configuration writes during a conversion only affect later conversions.
- R7: On the completion edge, `data_o` takes the most recent word presented with `res_valid_i`. At all other times `data_o` holds its value, including during a conversion.
- R8: `ready_o` stays high after completion until the next start, even while further result strobes arrive.
- R9: `busy_o` is high from the start edge up to the completion edge, and `busy_o` and `ready_o` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lo_we | input | 1 | Write strobe for the low setting byte |
| cfg_hi_we | input | 1 | Write strobe for the high setting byte |
| cfg_wdata | input | 8 | Byte written by either strobe |
| start_i | input | 1 | Start-conversion pulse |
| res_data_i | input | RES_W (24) | Result word from the filter |
| res_valid_i | input | 1 | Result word valid strobe |
| data_o | output | RES_W (24) | Published result of the last completed conversion |
| ready_o | output | 1 | Data-ready flag |
| busy_o | output | 1 | Conversion in progress |

## Verification
The bench sweeps the setting through many small values on a narrow build and counts edges from start to data-ready. An off-by-one compare or a missed prescale bit would show up as a count one clock or one 32-clock step away from 32·N. It also runs the zero setting, where a design without the wrap-to-maximum rule would finish at once or never. It restarts a conversion mid-window and rewrites the setting mid-window, which catches a counter that does not clear or a live, uncaptured compare value. It also checks that published data stays frozen mid-conversion and after completion, which exposes a single-buffered output. A wide build with a non-zero high byte catches swapped configuration bytes.

// File: rtl/integ_seq.sv
module integ_seq #(
  parameter int CNT_W  = 21,
  parameter int SET_W  = 16,
  parameter int RES_W  = 24,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_lo_we,
  input  logic             cfg_hi_we,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic             start_i,
  input  logic [RES_W-1:0] res_data_i,
  input  logic             res_valid_i,
  output logic [RES_W-1:0] data_o,
  output logic             ready_o,
  output logic             busy_o
);
  localparam int FRAC_W = CNT_W - SET_W;
  localparam int CFG_W  = 2 * BYTE_W;

  logic [CFG_W-1:0] cfg_q;
  logic [SET_W-1:0] per_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [RES_W-1:0] shadow_q, data_q;
  logic             busy_q, ready_q, done;

  assign cnt_nxt = cnt_q + 1'b1;
  assign done    = busy_q && (cnt_nxt[CNT_W-1:FRAC_W] == per_q)
                          && (cnt_nxt[FRAC_W-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else begin
      if (cfg_lo_we) cfg_q[BYTE_W-1:0]     <= cfg_wdata;
      if (cfg_hi_we) cfg_q[CFG_W-1:BYTE_W] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else if (res_valid_i) shadow_q <= res_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      data_q  <= '0;
    end else if (start_i) begin
      per_q   <= cfg_q[SET_W-1:0];
      cnt_q   <= '0;
      busy_q  <= 1'b1;
      ready_q <= 1'b0;
    end else if (done) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b1;
      data_q  <= res_valid_i ? res_data_i : shadow_q;
    end else if (busy_q) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign data_o  = data_q;
  assign ready_o = ready_q;
  assign busy_o  = busy_q;
endmodule

module integ_seq_chk #(
  parameter int RES_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [RES_W-1:0] data_o,
  input logic             ready_o,
  input logic             busy_o
);
  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && ready_o));
  // R5
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_o && !ready_o));
  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(ready_o) |-> $stable(data_o));
  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !start_i) |=> ready_o);
  // R3
  ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $fell(busy_o));
endmodule

bind integ_seq integ_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .data_o(data_o), .ready_o(ready_o), .busy_o(busy_o)
);

// File: tb/test_integ_seq.sv
`timescale 1ns/1ps
module test_integ_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lo_we = 1'b0, hi_we = 1'b0;
  logic [7:0]  wdata = '0;
  logic        start = 1'b0;
  logic [23:0] res = '0;
  logic        res_v = 1'b0;
  logic [23:0] data_b, data_s;
  logic        rdy_b, rdy_s, busy_b, busy_s;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  integ_seq i_integ_seq (
    .clk(clk), .rst_n(rst_n), .cfg_lo_we(lo_we), .cfg_hi_we(hi_we),
    .cfg_wdata(wdata), .start_i(start), .res_data_i(res), .res_valid_i(res_v),
    .data_o(data_b), .ready_o(rdy_b), .busy_o(busy_b));

  integ_seq #(.CNT_W(11), .SET_W(6)) i_integ_seq_s (
    .clk(clk), .rst_n(rst_n), .cfg_lo_we(lo_we), .cfg_hi_we(hi_we),
    .cfg_wdata(wdata), .start_i(start), .res_data_i(res), .res_valid_i(res_v),
    .data_o(data_s), .ready_o(rdy_s), .busy_o(busy_s));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic rdy(input bit sm);
    return sm ? rdy_s : rdy_b;
  endfunction
  function automatic logic bsy(input bit sm);
    return sm ? busy_s : busy_b;
  endfunction
  function automatic logic [23:0] dat(input bit sm);
    return sm ? data_s : data_b;
  endfunction

  task automatic wcfg(input logic [7:0] lo, input logic [7:0] hi);
    @(negedge clk); lo_we = 1'b1; wdata = lo;
    @(negedge clk); lo_we = 1'b0; hi_we = 1'b1; wdata = hi;
    @(negedge clk); hi_we = 1'b0;
  endtask

  // one conversion; mid_lo >= 0 rewrites the low byte at edge 10
  task automatic conv(input bit sm, input logic [23:0] w, input int exp_cyc,
                      input int mid_lo, input string req);
    logic [23:0] prev;
    int c;
    prev = dat(sm);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R5 start sets busy", bsy(sm), 1);
    chk("R5 start clears ready", rdy(sm), 0);
    c = 0;
    while (!rdy(sm) && c < 10000) begin
      if (c == 3) begin res = w; res_v = 1'b1; end
      if (c == 4) res_v = 1'b0;
      if (c == 10 && mid_lo >= 0) begin lo_we = 1'b1; wdata = mid_lo[7:0]; end
      if (c == 11) lo_we = 1'b0;
      if (c == 20) chk("R7 data held mid-conversion", dat(sm), prev);
      @(negedge clk);
      c++;
    end
    chk(req, c, exp_cyc);
    chk("R7 published result", dat(sm), w);
    chk("R9 busy low at completion", bsy(sm), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready after reset", rdy_b, 0);
    chk("R1 busy after reset", busy_b, 0);
    chk("R1 data after reset", data_s, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready idle", rdy_s, 0);

    // R3 sweep on the narrow build
    for (int n = 1; n <= 20; n++) begin
      wcfg(n[7:0], 8'h00);
      conv(1'b1, 24'h100000 + n * 24'h0131, 32 * n, -1, "R3 period 32*N");
    end
    wcfg(8'd63, 8'h00);
    conv(1'b1, 24'hABCDEF, 32 * 63, -1, "R3 period at max N");

    // R4 zero setting is the longest window
    wcfg(8'h00, 8'h00);
    conv(1'b1, 24'h800001, 64 * 32, -1, "R4 zero setting");

    // R2 byte order on the wide build
    wcfg(8'h02, 8'h01);
    conv(1'b0, 24'h7FFFFF, 258 * 32, -1, "R2 high byte weight");
    wcfg(8'h03, 8'h00);
    conv(1'b0, 24'h123456, 96, -1, "R2 low byte weight");

    // R5 restart mid-window
    wcfg(8'd2, 8'h00);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    chk("R5 still busy before restart", rdy_s, 0);
    conv(1'b1, 24'h0F0F0F, 64, -1, "R5 restart counts from zero");

    // R6 setting captured at start
    wcfg(8'd3, 8'h00);
    conv(1'b1, 24'h222222, 96, 5, "R6 mid write ignored");
    conv(1'b1, 24'h333333, 160, -1, "R6 new setting used next time");

    // R8 ready and data hold while idle
    repeat (10) @(negedge clk);
    res = 24'h999999; res_v = 1'b1;
    @(negedge clk); res_v = 1'b0;
    repeat (40) @(negedge clk);
    chk("R8 ready stays high", rdy_s, 1);
    chk("R8 data unchanged by idle strobe", data_s, 24'h333333);
    chk("R9 busy low while idle", busy_s, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule